// File: doc/BRIEF.md
# Timer Output-Compare Unit

This block holds a small set of output-compare channels that watch a free-running time counter kept elsewhere. For each channel, software loads a compare value and picks a mode. When the counter steps onto that value, the channel latches an event flag, can assert its interrupt line, and moves its output pin: the pin either flips, or it goes high for one clock.

Each channel has two compare slots. The first value written arms the channel. A second write parks the following compare point behind it, and a match moves the parked value forward. Software can therefore keep the schedule one step ahead of the hardware, for example to build a once-per-second pulse. The flags are cleared by writing 1 to them. A single status word collects the flags of all channels.

The counter is an input. So is `cnt_upd`, which marks the clocks on which the counter takes a new value. Software reaches the registers through a simple write strobe and a combinational read port.

Top module: `tc_compare_unit`

## Requirements
- R1: After reset every pin and interrupt output is low, and every channel control word, every compare readback and the status word read 0.
- R2: The status word is at byte address 0x04. Channel n has its control word at 0x08+8n and its compare word 4 bytes above that. In the control word, bit 0 is a stored DMA-request enable with no other effect, bits 5:2 are the mode, bit 6 is the interrupt enable and bit 7 is the event flag. Bit n of the status word is the flag of channel n. Any other address reads 0.
- R3: A match happens on a clock where `cnt_upd` is 1, the channel holds an armed compare value equal to `cnt_val`, and the mode is 0x5 or 0xF. The flag is set at that edge. When `cnt_upd` is 0, no match happens.
- R4: In mode 0x5 the pin inverts at every match.
- R5: In mode 0xF the pin is high for exactly the one clock that follows a match.
- R6: A control write with bit 7 set clears the flag. A control write with bit 7 clear leaves the flag as it is. When a match and a clearing write fall on the same clock, the flag ends up set.
- R7: The interrupt output of a channel is high exactly while its flag and its interrupt enable are both 1.
- R8: A compare write arms the channel when no value is armed, and otherwise queues the value, replacing any value already queued. On a match, the queued value becomes the armed value. If nothing is queued, the channel is left unarmed and does not match again until the next write. A write on the same clock as a match goes into the first slot that the match leaves free.
- R9: Writing mode 0 empties both compare slots and drives the pin low. While the mode is 0, no match happens.
- R10: Any mode other than 0, 0x5 and 0xF is stored and read back, but it never produces a match. The pin holds its level and the compare slots keep their contents.
- R11: A read of the compare word returns the armed compare value. After the channel is left unarmed, it returns the last value that was armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current time-counter value |
| cnt_upd | input | 1 | Counter takes a new value on this clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| pin_out | output | N_CH | Per-channel compare output pin |
| irq | output | N_CH | Per-channel interrupt |

## Verification
The bench targets the compare slots. It checks that a third write replaces the queued value, that a channel left unarmed stops matching, and that a compare write on the same clock as a match is promoted correctly. A design that mishandles these either misses a match or fires at a stale value. It also drives a match and a flag-clearing write on the same clock; a design that gives the clear priority would lose the event. Mode 0 must flush a pending schedule: a design that only stops the pin would fire at an old value once the channel is enabled again. Finally, the bench confirms that an unsupported mode leaves the pin alone and never raises the flag, and that a clock with `cnt_upd` low never matches even when the count is equal.

// File: rtl/tc_pkg.sv
// Shared field positions and mode codes for the timer compare unit.
// Assumes a 32-bit register data path.
package tc_pkg;
    localparam int CTRL_DRE  = 0;
    localparam int MODE_LO   = 2;
    localparam int MODE_W    = 4;
    localparam int CTRL_IE   = 6;
    localparam int CTRL_FLAG = 7;
    localparam int DATA_W    = 32;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
    localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;
endpackage

// File: rtl/tc_cmp_buffer.sv
// Two-slot compare store: an armed (active) slot and a queued slot.
// Each clock applies, in this order: promotion on consume, then a load into
// the first free slot (the queued slot is overwritten when both are full),
// then a flush that empties both slots.
// Assumes consume is only raised while the active slot is valid.
module tc_cmp_buffer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         consume,
    output logic [W-1:0] act_val,
    output logic         act_vld
);
    logic [W-1:0] act_q, que_q, act_n, que_n;
    logic         act_vld_q, que_vld_q, act_vld_n, que_vld_n;

    // Next-state of both slots from promotion, load and flush.
    always_comb begin
        act_n     = act_q;
        que_n     = que_q;
        act_vld_n = act_vld_q;
        que_vld_n = que_vld_q;
        if (consume) begin
            if (que_vld_q) begin
                act_n     = que_q;
                act_vld_n = 1'b1;
                que_vld_n = 1'b0;
            end else begin
                act_vld_n = 1'b0;
            end
        end
        if (load) begin
            if (!act_vld_n) begin
                act_n     = load_val;
                act_vld_n = 1'b1;
            end else begin
                que_n     = load_val;
                que_vld_n = 1'b1;
            end
        end
        if (flush) begin
            act_vld_n = 1'b0;
            que_vld_n = 1'b0;
        end
    end

    // Slot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= '0;
            que_q     <= '0;
            act_vld_q <= 1'b0;
            que_vld_q <= 1'b0;
        end else begin
            act_q     <= act_n;
            que_q     <= que_n;
            act_vld_q <= act_vld_n;
            que_vld_q <= que_vld_n;
        end
    end

    assign act_val = act_q;
    assign act_vld = act_vld_q;

    // R8: a value can only wait in the queue behind an armed value.
    a_r8_queue_behind_active: assert property (@(posedge clk) disable iff (!rst_n)
        que_vld_q |-> act_vld_q);

    // R8: a match with a queued value promotes exactly that value.
    a_r8_promote: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && que_vld_q && !load && !flush) |=> (act_vld_q && act_q == $past(que_q)));
endmodule

// File: rtl/tc_channel.sv
// One output-compare channel: control/status word, two-slot compare store,
// match detection, event flag and output pin.
// Assumes CNT_W <= 32. The counter value is trusted only when cnt_upd is 1.
module tc_channel
    import tc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_upd,
    input  logic              ctrl_we,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] cmp_rd,
    output logic              flag,
    output logic              irq,
    output logic              pin
);
    logic              dre_q, ie_q, flag_q, pin_q;
    logic [MODE_W-1:0] mode_q, mode_n;
    logic [CNT_W-1:0]  act_val;
    logic              act_vld, cmp_mode, hit, flush;

    assign mode_n   = ctrl_we ? wdata[MODE_LO +: MODE_W] : mode_q;
    assign cmp_mode = (mode_q == MODE_TOGGLE) || (mode_q == MODE_PULSE);
    assign hit      = cnt_upd && cmp_mode && act_vld && (cnt_val == act_val);
    assign flush    = ctrl_we && (wdata[MODE_LO +: MODE_W] == MODE_OFF);

    tc_cmp_buffer #(.W(CNT_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .load     (cmp_we),
        .load_val (wdata[CNT_W-1:0]),
        .consume  (hit),
        .act_val  (act_val),
        .act_vld  (act_vld)
    );

    // Configuration fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dre_q  <= 1'b0;
            ie_q   <= 1'b0;
            mode_q <= MODE_OFF;
        end else if (ctrl_we) begin
            dre_q  <= wdata[CTRL_DRE];
            ie_q   <= wdata[CTRL_IE];
            mode_q <= wdata[MODE_LO +: MODE_W];
        end
    end

    // Event flag: set on a match, cleared by writing 1; the match wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (ctrl_we && wdata[CTRL_FLAG])
            flag_q <= 1'b0;
    end

    // Output pin: low when off, flips in toggle mode, one-clock pulse in pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (mode_n == MODE_OFF)
            pin_q <= 1'b0;
        else if (mode_q == MODE_TOGGLE)
            pin_q <= hit ? ~pin_q : pin_q;
        else if (mode_q == MODE_PULSE)
            pin_q <= hit;
    end

    assign ctrl_rd = {24'd0, flag_q, ie_q, mode_q, 1'b0, dre_q};
    assign cmp_rd  = DATA_W'(act_val);
    assign flag    = flag_q;
    assign irq     = flag_q && ie_q;
    assign pin     = pin_q;

    // R3: the flag only rises after a qualified match.
    a_r3_flag_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit));

    // R4: a match in toggle mode changes the pin level.
    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MODE_TOGGLE && !ctrl_we) |=> (pin_q != $past(pin_q)));

    // R5: in pulse mode the pin is high only on the clock after a match.
    a_r5_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q && $past(mode_q) == MODE_PULSE) |-> $past(hit));

    // R9: a disabled channel keeps its pin low.
    a_r9_off_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |-> !pin_q);
endmodule

// File: rtl/tc_compare_unit.sv
// Top of the timer compare unit: N_CH output-compare channels, register
// address decode, read mux and the collected status word.
// Assumes byte addresses on a 32-bit word bus, with no two registers mapped
// to the same address.
module tc_compare_unit
    import tc_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 'h04,
    parameter int CH_BASE   = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_upd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [N_CH-1:0]   pin_out,
    output logic [N_CH-1:0]   irq
);
    localparam int CH_SPAN = 8;
    localparam int CMP_OFS = 4;

    logic [DATA_W-1:0] ctrl_rd [N_CH];
    logic [DATA_W-1:0] cmp_rd  [N_CH];
    logic [N_CH-1:0]   flags;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + ch * CH_SPAN);
        localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CH_BASE + ch * CH_SPAN + CMP_OFS);

        tc_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_val (cnt_val),
            .cnt_upd (cnt_upd),
            .ctrl_we (wr_en && (wr_addr == A_CTRL)),
            .cmp_we  (wr_en && (wr_addr == A_CMP)),
            .wdata   (wr_data),
            .ctrl_rd (ctrl_rd[ch]),
            .cmp_rd  (cmp_rd[ch]),
            .flag    (flags[ch]),
            .irq     (irq[ch]),
            .pin     (pin_out[ch])
        );
    end

    // Read mux over the status word and every channel register.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(STAT_ADDR))
            rd_data = 32'(flags);
        for (int i = 0; i < N_CH; i++) begin
            if (rd_addr == ADDR_W'(CH_BASE + i * CH_SPAN))
                rd_data = ctrl_rd[i];
            if (rd_addr == ADDR_W'(CH_BASE + i * CH_SPAN + CMP_OFS))
                rd_data = cmp_rd[i];
        end
    end

    // R7: no interrupt line is high unless its channel flag is set.
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~flags) == '0);
endmodule

// File: tb/tc_compare_unit_tb.sv
module tc_compare_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_val = '0;
    logic        cnt_upd = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pin_out;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tc_compare_unit u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_val (cnt_val),
        .cnt_upd (cnt_upd),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pin_out (pin_out),
        .irq     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [31:0] c, input logic u);
        @(negedge clk);
        cnt_val = c; cnt_upd = u;
        @(negedge clk);
        cnt_upd = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pins", 32'(pin_out), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(8'h04, d); chk("R1 status", d, 0);
        rd(8'h08, d); chk("R1 ch0 ctrl", d, 0);
        rd(8'h24, d); chk("R1 ch3 cmp", d, 0);
    endtask

    task automatic t_layout_other_mode();
        logic [31:0] d;
        wr(8'h10, 32'h4D);
        wr(8'h14, 32'h1234);
        rd(8'h10, d); chk("R2 ch1 ctrl fields", d, 32'h4D);
        rd(8'h08, d); chk("R2 ch0 ctrl untouched", d, 0);
        rd(8'h14, d); chk("R11 ch1 cmp readback", d, 32'h1234);
        rd(8'h00, d); chk("R2 unmapped reads 0", d, 0);
        step(32'h1234, 1'b1);
        rd(8'h04, d); chk("R10 no flag in other mode", d, 0);
        chk("R10 pin holds", 32'(pin_out[1]), 0);
        rd(8'h14, d); chk("R10 slot kept", d, 32'h1234);
    endtask

    task automatic t_toggle();
        logic [31:0] d;
        wr(8'h08, 32'h54);
        wr(8'h0C, 100);
        wr(8'h0C, 200);
        step(99, 1'b1);
        rd(8'h04, d); chk("R3 no match on other value", d, 0);
        step(100, 1'b0);
        rd(8'h04, d); chk("R3 no match without cnt_upd", d, 0);
        step(100, 1'b1);
        rd(8'h04, d); chk("R3 flag in status bit0", d, 1);
        chk("R4 pin toggled high", 32'(pin_out[0]), 1);
        chk("R7 irq with enable", 32'(irq[0]), 1);
        rd(8'h0C, d); chk("R8 queued value promoted", d, 200);
        wr(8'h08, 32'hD4);
        rd(8'h04, d); chk("R6 write-1 clears flag", d, 0);
        chk("R7 irq drops with flag", 32'(irq[0]), 0);
        chk("R6 clear leaves pin", 32'(pin_out[0]), 1);
        step(200, 1'b1);
        chk("R4 pin toggled low", 32'(pin_out[0]), 0);
        wr(8'h08, 32'h54);
        rd(8'h04, d); chk("R6 write-0 keeps flag", d, 1);
        wr(8'h08, 32'hD4);
        step(200, 1'b1);
        rd(8'h04, d); chk("R8 unarmed after last match", d, 0);
        rd(8'h0C, d); chk("R11 last armed value kept", d, 200);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(8'h0C, 300);
        step(300, 1'b1);
        chk("R4 pin high before disable", 32'(pin_out[0]), 1);
        wr(8'h0C, 400);
        wr(8'h0C, 500);
        wr(8'h08, 32'h80);
        chk("R9 mode 0 drives pin low", 32'(pin_out[0]), 0);
        rd(8'h08, d); chk("R9 ctrl reads off and clear", d, 0);
        wr(8'h08, 32'h54);
        step(400, 1'b1);
        rd(8'h04, d); chk("R9 slots flushed", d, 0);
        chk("R9 pin stays low", 32'(pin_out[0]), 0);
    endtask

    task automatic t_pulse();
        logic [31:0] d;
        wr(8'h18, 32'h3C);
        wr(8'h1C, 10);
        step(10, 1'b1);
        chk("R5 pulse high", 32'(pin_out[2]), 1);
        rd(8'h04, d); chk("R2 status bit2", d, 4);
        chk("R7 no irq without enable", 32'(irq[2]), 0);
        @(negedge clk);
        chk("R5 pulse one clock", 32'(pin_out[2]), 0);
    endtask

    task automatic t_queue_replace();
        logic [31:0] d;
        wr(8'h18, 32'hBC);
        wr(8'h1C, 20);
        wr(8'h1C, 30);
        wr(8'h1C, 40);
        step(20, 1'b1);
        rd(8'h04, d); chk("R8 armed value matches", (d >> 2) & 1, 1);
        wr(8'h18, 32'hBC);
        step(30, 1'b1);
        rd(8'h04, d); chk("R8 replaced queue skips 30", (d >> 2) & 1, 0);
        step(40, 1'b1);
        rd(8'h04, d); chk("R8 replacement value matches", (d >> 2) & 1, 1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        wr(8'h20, 32'h3C);
        wr(8'h24, 50);
        @(negedge clk);
        cnt_val = 50; cnt_upd = 1'b1;
        wr_en = 1'b1; wr_addr = 8'h24; wr_data = 60;
        @(negedge clk);
        cnt_upd = 1'b0; wr_en = 1'b0;
        rd(8'h04, d); chk("R3 ch3 match", (d >> 3) & 1, 1);
        rd(8'h24, d); chk("R8 write during match arms", d, 60);
        @(negedge clk);
        cnt_val = 60; cnt_upd = 1'b1;
        wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'hBC;
        @(negedge clk);
        cnt_upd = 1'b0; wr_en = 1'b0;
        rd(8'h04, d); chk("R6 match beats clear", (d >> 3) & 1, 1);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout_other_mode();
        t_toggle();
        t_disable();
        t_pulse();
        t_queue_replace();
        t_same_cycle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule